// File: doc/BRIEF.md
# Circular buffer period fetch engine

The engine drains audio data, a period at a time, from a circular buffer in a device memory into a linear destination buffer. Before a run it is loaded with six values: the ring base, the ring limit, the current read pointer, the total number of bytes to fetch, the period size and the destination buffer size. A programmable pacing delay is loaded with them. For each period the engine issues one or two burst reads to a downstream reader. It cuts every burst into chunks, hands them over one at a time, and waits until each chunk is reported complete.

A period that would run past the ring limit is split in two. The first part reads up to the limit. The second part reads the rest from the ring base. The last period of a run is cut down to whatever remains of the total. After each period the engine pulses a period-elapsed output and moves its destination offset forward, and the offset returns to zero when it reaches the end of the destination buffer. The first period starts at once. Each later period waits for the pacing delay. The reader and both memories sit outside the block. The expected use is a destination buffer of at most 128 KiB, split into exactly 8 periods of 16-bit mono samples.

Top module: `ring_fetch_eng`

## Requirements
- R1: A start pulse is accepted only in idle and only when base, limit, read pointer and total are all nonzero. A rejected start leaves `busy_o` low, issues no request and leaves `done_o` unchanged.
- R2: Each step moves min(period, total minus bytes already fetched) bytes. The run ends when the fetched count equals the total.
- R3: If read pointer + step ≤ limit, the step issues a single burst from the read pointer. The read pointer then advances by the step, or becomes base when it lands exactly on the limit.
- R4: If read pointer + step > limit, the step issues a first burst of (limit − read pointer) bytes from the read pointer. It then issues a second burst of the rest from base, at destination offset + first length. The read pointer becomes base + rest.
- R5: At the end of a step, `dst_off_o` advances by the step length. It becomes 0 if the new value is at or above the destination buffer size. It changes at no other time except when a start is accepted.
- R6: Each completed step raises `period_o` for exactly one cycle, in the same cycle that the new `dst_off_o` appears.
- R7: The first request is valid 2 cycles after the cycle in which start is sampled. A later step's first request is valid D+1 cycles after the `period_o` cycle. D is `delay_i`, and a `delay_i` of 0 selects 5.
- R8: Each chunk has a length of at most 240, is nonzero, and is a multiple of 8 (bits [2:0] zero) when all configured values are multiples of 8. Chunks of a burst follow in address order.
- R9: While `req_valid_o` is high and `req_done_i` is low, the request's source, destination and length hold stable.
- R10: Abort during the pacing delay returns the engine to idle on the next cycle. Abort while a burst is outstanding lets that burst finish, then returns to idle with no further request and no period pulse.
- R11: `done_o` rises together with the last `period_o` of a run and stays high while idle. An accepted start clears it and sets `dst_off_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle |
| abort_i | input | 1 | Cancel the run at the next clean boundary |
| base_i | input | AW | Ring base address |
| limit_i | input | AW | Ring limit address (exclusive end) |
| rdptr_i | input | AW | Initial read pointer |
| total_i | input | TW | Total bytes to fetch |
| period_i | input | LW | Period size in bytes |
| dbuf_i | input | LW | Destination buffer size in bytes |
| delay_i | input | DW | Pacing delay in cycles, 0 selects default |
| req_valid_o | output | 1 | Chunk request outstanding |
| req_src_o | output | AW | Chunk source address |
| req_dst_o | output | LW | Chunk destination offset |
| req_len_o | output | CLW | Chunk length in bytes |
| req_done_i | input | 1 | Reader reports the current chunk complete |
| period_o | output | 1 | One-cycle period-elapsed pulse |
| dst_off_o | output | LW | Current destination offset |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run fetched its full total |

## Verification
The assertions assume that the configuration inputs hold steady during a run. They also assume that base ≤ read pointer < limit, that the period is nonzero, and that all addresses and sizes are multiples of 8, which is why the chunk-shape property checks alignment. They further assume that `req_done_i` is only meaningful while a request is valid. The bench sets up every configuration before it pulses start, and uses only aligned values whose read pointer lies inside the ring. Its reader raises `req_done_i` for a single cycle, and only against a valid request, after a latency that it varies.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLAN,
    ST_B1,
    ST_B2,
    ST_WAIT
  } fetch_st_e;
endpackage

// File: rtl/ring_step_plan.sv
module ring_step_plan #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 18,
  parameter int unsigned TW = 32
) (
  input  logic [AW-1:0] rp_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic [TW-1:0] remain_i,
  input  logic [LW-1:0] period_i,
  output logic [LW-1:0] step_o,
  output logic [LW-1:0] first_o,
  output logic [LW-1:0] rest_o,
  output logic          split_o,
  output logic [AW-1:0] nrp_o
);
  logic [AW:0]   sum;
  logic [AW-1:0] gap;

  always_comb begin
    step_o  = (remain_i < {{(TW-LW){1'b0}}, period_i}) ? remain_i[LW-1:0] : period_i;
    sum     = {1'b0, rp_i} + {{(AW+1-LW){1'b0}}, step_o};
    split_o = sum > {1'b0, limit_i};
    gap     = limit_i - rp_i;
    first_o = split_o ? gap[LW-1:0] : step_o;
    rest_o  = step_o - first_o;
    if (split_o)
      nrp_o = base_i + {{(AW-LW){1'b0}}, rest_o};
    else if (sum[AW-1:0] == limit_i)
      nrp_o = base_i;
    else
      nrp_o = sum[AW-1:0];
  end
endmodule

// File: rtl/ring_chunker.sv
module ring_chunker #(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 18,
  parameter int unsigned CLW       = 8,
  parameter int unsigned CHUNK_MAX = 240
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] go_src_i,
  input  logic [LW-1:0] go_dst_i,
  input  logic [LW-1:0] go_len_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_src_o,
  output logic [LW-1:0] req_dst_o,
  output logic [CLW-1:0] req_len_o,
  input  logic          req_done_i,
  output logic          fin_o
);
  localparam logic [LW-1:0] CMAX = LW'(CHUNK_MAX);

  logic          vld_q;
  logic [AW-1:0] src_q;
  logic [LW-1:0] dst_q;
  logic [LW-1:0] rem_q;
  logic [LW-1:0] clen;

  assign clen        = (rem_q > CMAX) ? CMAX : rem_q;
  assign fin_o       = vld_q && req_done_i && (rem_q == clen);
  assign req_valid_o = vld_q;
  assign req_src_o   = src_q;
  assign req_dst_o   = dst_q;
  assign req_len_o   = clen[CLW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else if (go_i) begin
      vld_q <= 1'b1;
      src_q <= go_src_i;
      dst_q <= go_dst_i;
      rem_q <= go_len_i;
    end else if (vld_q && req_done_i) begin
      if (fin_o) begin
        vld_q <= 1'b0;
      end else begin
        src_q <= src_q + {{(AW-LW){1'b0}}, clen};
        dst_q <= dst_q + clen;
        rem_q <= rem_q - clen;
      end
    end
  end
endmodule

// File: rtl/ring_pace_timer.sv
module ring_pace_timer #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] val_i,
  input  logic          clr_i,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q;

  assign expire_o = (cnt_q == DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - DW'(1);
  end
endmodule

// File: rtl/ring_fetch_eng.sv
module ring_fetch_eng
  import ring_fetch_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 18,
  parameter int unsigned TW        = 32,
  parameter int unsigned DW        = 16,
  parameter int unsigned CLW       = 8,
  parameter int unsigned CHUNK_MAX = 240,
  parameter int unsigned DEF_DELAY = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           abort_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  limit_i,
  input  logic [AW-1:0]  rdptr_i,
  input  logic [TW-1:0]  total_i,
  input  logic [LW-1:0]  period_i,
  input  logic [LW-1:0]  dbuf_i,
  input  logic [DW-1:0]  delay_i,
  output logic           req_valid_o,
  output logic [AW-1:0]  req_src_o,
  output logic [LW-1:0]  req_dst_o,
  output logic [CLW-1:0] req_len_o,
  input  logic           req_done_i,
  output logic           period_o,
  output logic [LW-1:0]  dst_off_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam logic [DW-1:0] DLY_DEF = DW'(DEF_DELAY);

  fetch_st_e     st_q;
  logic [AW-1:0] base_q, limit_q, rp_q, nrp_q;
  logic [TW-1:0] total_q, fetched_q;
  logic [LW-1:0] per_q, dbuf_q, off_q;
  logic [LW-1:0] step_q, first_q, rest_q;
  logic          split_q;
  logic [DW-1:0] dly_q;
  logic          abort_q, period_q, done_q;

  logic [LW-1:0] p_step, p_first, p_rest;
  logic          p_split;
  logic [AW-1:0] p_nrp;
  logic [TW-1:0] remain;

  logic          ck_go, ck_fin;
  logic [AW-1:0] ck_src;
  logic [LW-1:0] ck_dst, ck_len;

  logic          cfg_ok, abort_any, step_end, last_step;
  logic [TW-1:0] fetched_nx;
  logic [LW:0]   off_sum;
  logic [LW-1:0] off_nx;
  logic          tm_exp;
  logic [DW-1:0] tm_val;

  assign remain = total_q - fetched_q;

  ring_step_plan #(.AW(AW), .LW(LW), .TW(TW)) u_plan (
    .rp_i     (rp_q),
    .base_i   (base_q),
    .limit_i  (limit_q),
    .remain_i (remain),
    .period_i (per_q),
    .step_o   (p_step),
    .first_o  (p_first),
    .rest_o   (p_rest),
    .split_o  (p_split),
    .nrp_o    (p_nrp)
  );

  ring_chunker #(.AW(AW), .LW(LW), .CLW(CLW), .CHUNK_MAX(CHUNK_MAX)) u_chunk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (ck_go),
    .go_src_i    (ck_src),
    .go_dst_i    (ck_dst),
    .go_len_i    (ck_len),
    .req_valid_o (req_valid_o),
    .req_src_o   (req_src_o),
    .req_dst_o   (req_dst_o),
    .req_len_o   (req_len_o),
    .req_done_i  (req_done_i),
    .fin_o       (ck_fin)
  );

  assign tm_val = (dly_q == '0) ? DLY_DEF : dly_q;

  ring_pace_timer #(.DW(DW)) u_pace (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (step_end && !last_step),
    .val_i    (tm_val),
    .clr_i    (abort_any),
    .expire_o (tm_exp)
  );

  always_comb begin
    cfg_ok    = (|base_i) && (|limit_i) && (|rdptr_i) && (|total_i);
    abort_any = abort_i || abort_q;
    ck_go     = 1'b0;
    ck_src    = rp_q;
    ck_dst    = off_q;
    ck_len    = p_first;
    if (st_q == ST_PLAN) begin
      ck_go = !abort_any;
    end else if (st_q == ST_B1 && ck_fin && split_q && !abort_any) begin
      ck_go  = 1'b1;
      ck_src = base_q;
      ck_dst = off_q + first_q;
      ck_len = rest_q;
    end
    step_end   = ck_fin && !abort_any &&
                 ((st_q == ST_B1 && !split_q) || st_q == ST_B2);
    fetched_nx = fetched_q + {{(TW-LW){1'b0}}, step_q};
    last_step  = fetched_nx >= total_q;
    off_sum    = {1'b0, off_q} + {1'b0, step_q};
    off_nx     = (off_sum >= {1'b0, dbuf_q}) ? '0 : off_sum[LW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      base_q    <= '0;
      limit_q   <= '0;
      rp_q      <= '0;
      nrp_q     <= '0;
      total_q   <= '0;
      fetched_q <= '0;
      per_q     <= '0;
      dbuf_q    <= '0;
      off_q     <= '0;
      step_q    <= '0;
      first_q   <= '0;
      rest_q    <= '0;
      split_q   <= 1'b0;
      dly_q     <= '0;
      abort_q   <= 1'b0;
      period_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      period_q <= 1'b0;
      abort_q  <= (st_q != ST_IDLE) && abort_any;
      if (step_end) begin
        rp_q      <= nrp_q;
        fetched_q <= fetched_nx;
        off_q     <= off_nx;
        period_q  <= 1'b1;
        done_q    <= last_step;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (start_i && cfg_ok) begin
            base_q    <= base_i;
            limit_q   <= limit_i;
            rp_q      <= rdptr_i;
            total_q   <= total_i;
            per_q     <= period_i;
            dbuf_q    <= dbuf_i;
            dly_q     <= delay_i;
            fetched_q <= '0;
            off_q     <= '0;
            done_q    <= 1'b0;
            st_q      <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (abort_any) begin
            st_q <= ST_IDLE;
          end else begin
            step_q  <= p_step;
            first_q <= p_first;
            rest_q  <= p_rest;
            split_q <= p_split;
            nrp_q   <= p_nrp;
            st_q    <= ST_B1;
          end
        end
        ST_B1, ST_B2: begin
          if (ck_fin) begin
            if (abort_any)                     st_q <= ST_IDLE;
            else if (st_q == ST_B1 && split_q) st_q <= ST_B2;
            else if (last_step)                st_q <= ST_IDLE;
            else                               st_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (abort_any)   st_q <= ST_IDLE;
          else if (tm_exp) st_q <= ST_PLAN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign period_o  = period_q;
  assign dst_off_o = off_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk #(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 18,
  parameter int unsigned CLW       = 8,
  parameter int unsigned CHUNK_MAX = 240
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           abort_i,
  input logic           req_valid_o,
  input logic [AW-1:0]  req_src_o,
  input logic [LW-1:0]  req_dst_o,
  input logic [CLW-1:0] req_len_o,
  input logic           req_done_i,
  input logic           period_o,
  input logic [LW-1:0]  dst_off_o,
  input logic           busy_o,
  input logic           done_o
);
  // R8: chunk shape, given 8-aligned configuration
  a_r8_chunk_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0) && (int'(req_len_o) <= CHUNK_MAX) && (req_len_o[2:0] == 3'b000));

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_done_i) |=> (req_valid_o && $stable(req_src_o) &&
                                      $stable(req_dst_o) && $stable(req_len_o)));

  a_r6_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |=> !period_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);

  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r5_off_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && !$stable(dst_off_o)) |-> period_o);

  // R10: abort with no request outstanding (plan or pacing) idles at once
  a_r10_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o && !req_valid_o) |=> !busy_o);
endmodule

bind ring_fetch_eng ring_fetch_chk #(
  .AW(AW), .LW(LW), .CLW(CLW), .CHUNK_MAX(CHUNK_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .abort_i     (abort_i),
  .req_valid_o (req_valid_o),
  .req_src_o   (req_src_o),
  .req_dst_o   (req_dst_o),
  .req_len_o   (req_len_o),
  .req_done_i  (req_done_i),
  .period_o    (period_o),
  .dst_off_o   (dst_off_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/tb_ring_fetch_eng.sv
module tb_ring_fetch_eng;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0;
  logic [31:0] base = '0, limit = '0, rdptr = '0, total = '0;
  logic [17:0] period = '0, dbuf = '0;
  logic [15:0] delay = '0;
  logic        req_valid, req_done = 1'b0;
  logic [31:0] req_src;
  logic [17:0] req_dst, dst_off;
  logic [7:0]  req_len;
  logic        period_p, busy, done;

  ring_fetch_eng dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .base_i(base), .limit_i(limit), .rdptr_i(rdptr), .total_i(total),
    .period_i(period), .dbuf_i(dbuf), .delay_i(delay),
    .req_valid_o(req_valid), .req_src_o(req_src), .req_dst_o(req_dst),
    .req_len_o(req_len), .req_done_i(req_done),
    .period_o(period_p), .dst_off_o(dst_off), .busy_o(busy), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int ncyc = 0, nreq = 0, npulse = 0, wcnt = 0;
  int gap_ref = 0, gap_exp = 0, cur_dly = 5;
  bit prev_v = 0, slow = 0;
  int unsigned q_src[$], q_dst[$], q_len[$], q_off[$];
  int unsigned model_off;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_burst(input int unsigned src, input int unsigned dst, input int unsigned len);
    int unsigned left = len;
    while (left > 0) begin
      int unsigned c = (left > 240) ? 240 : left;
      q_src.push_back(src); q_dst.push_back(dst); q_len.push_back(c);
      src += c; dst += c; left -= c;
    end
  endtask

  // Reference: expected chunk stream and pulse offsets from the requirements
  task automatic build_model(input int unsigned b, input int unsigned l, input int unsigned r,
                             input int unsigned t, input int unsigned p, input int unsigned d);
    int unsigned got = 0, off = 0, rp = r;
    while (got < t) begin
      int unsigned s = ((t - got) < p) ? (t - got) : p;
      if (rp + s <= l) begin
        push_burst(rp, off, s);
        rp = (rp + s == l) ? b : rp + s;
      end else begin
        int unsigned f = l - rp;
        push_burst(rp, off, f);
        push_burst(b, off + f, s - f);
        rp = b + s - f;
      end
      off += s;
      if (off >= d) off = 0;
      q_off.push_back(off);
      got += s;
    end
    model_off = off;
  endtask

  task automatic clear_model();
    q_src.delete(); q_dst.delete(); q_len.delete(); q_off.delete();
  endtask

  task automatic cfg(input int unsigned b, input int unsigned l, input int unsigned r,
                     input int unsigned t, input int unsigned p, input int unsigned d,
                     input int unsigned dl);
    base = b; limit = l; rdptr = r; total = t;
    period = 18'(p); dbuf = 18'(d); delay = 16'(dl);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run_job(input int unsigned b, input int unsigned l, input int unsigned r,
                         input int unsigned t, input int unsigned p, input int unsigned d,
                         input int unsigned dl, input string name);
    cfg(b, l, r, t, p, d, dl);
    cur_dly = (dl == 0) ? 5 : dl;
    clear_model();
    build_model(b, l, r, t, p, d);
    pulse_start();
    @(negedge clk);
    chk(busy, {name, " R1 start accepted"}, busy, 1);
    chk(!done, {name, " R11 done cleared on start"}, done, 0);
    chk(dst_off == 0, {name, " R11 offset cleared on start"}, dst_off, 0);
    wait_idle();
    chk(q_src.size() == 0, {name, " R2 all chunks issued"}, q_src.size(), 0);
    chk(q_off.size() == 0, {name, " R6 all pulses seen"}, q_off.size(), 0);
    chk(done, {name, " R11 done at end"}, done, 1);
    chk(dst_off == 18'(model_off), {name, " R5 final offset"}, dst_off, model_off);
  endtask

  // Monitor and reader model, one pass per negedge
  initial begin
    forever begin
      @(negedge clk);
      ncyc++;
      if (!rst_n) begin
        req_done = 1'b0; wcnt = 0; prev_v = 0;
      end else begin
        if (period_p) begin
          npulse++;
          if (q_off.size() == 0) chk(0, "R6 unexpected pulse", 1, 0);
          else begin
            chk(dst_off == 18'(q_off[0]), "R5 offset at pulse", dst_off, q_off[0]);
            void'(q_off.pop_front());
          end
          gap_ref = ncyc; gap_exp = cur_dly + 1;
        end
        if (start && !busy) begin
          gap_ref = ncyc; gap_exp = 2;
        end
        if (req_valid && !prev_v && gap_exp != 0) begin
          chk(ncyc - gap_ref == gap_exp, "R7 request spacing", ncyc - gap_ref, gap_exp);
          gap_exp = 0;
        end
        if (req_done) begin
          req_done = 1'b0; wcnt = 0;
        end else if (req_valid) begin
          if (wcnt >= (slow ? 6 : nreq % 3)) begin
            if (q_src.size() == 0) chk(0, "R10 unexpected request", req_src, 0);
            else begin
              chk(req_src == q_src[0], "R3/R4 chunk source", req_src, q_src[0]);
              chk(req_dst == 18'(q_dst[0]), "R4 chunk destination", req_dst, q_dst[0]);
              chk(req_len == 8'(q_len[0]), "R8 chunk length", req_len, q_len[0]);
              void'(q_src.pop_front()); void'(q_dst.pop_front()); void'(q_len.pop_front());
            end
            nreq++;
            req_done = 1'b1;
          end else wcnt++;
        end
        prev_v = req_valid;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n0, p0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "reset busy", busy, 0);
    chk(!req_valid, "reset request", req_valid, 0);
    chk(!done, "R11 reset done", done, 0);
    chk(dst_off == 0, "R5 reset offset", dst_off, 0);
    chk(!period_p, "R6 reset pulse", period_p, 0);

    // R3: exact landing on limit wraps; short last step (R2)
    run_job(32'h1000, 32'h1800, 32'h1200, 32'h900, 32'h200, 32'h1000, 3, "T1");

    // R1: any zero field rejects, done stays set
    for (int k = 0; k < 4; k++) begin
      n0 = nreq;
      cfg((k == 0) ? 0 : 32'h1000, (k == 1) ? 0 : 32'h1800, (k == 2) ? 0 : 32'h1200,
          (k == 3) ? 0 : 32'h900, 32'h200, 32'h1000, 3);
      pulse_start();
      repeat (4) @(negedge clk);
      chk(!busy, "R1 rejected start idle", busy, 0);
      chk(done, "R1 rejected start keeps done", done, 1);
      chk(nreq == n0, "R1 rejected start no request", nreq - n0, 0);
    end

    // R4 + R5: crossing split, offset wrap, default delay (R7)
    run_job(32'h2000, 32'h2300, 32'h2280, 32'h300, 32'h100, 32'h200, 0, "T2");
    // R4: crossing with multi-chunk bursts
    run_job(32'h8000, 32'h8400, 32'h8300, 32'h800, 32'h400, 32'h2000, 2, "T3");

    // R10: abort during pacing delay
    cfg(32'h1000, 32'h1800, 32'h1200, 32'h900, 32'h200, 32'h1000, 20);
    cur_dly = 20; clear_model();
    build_model(32'h1000, 32'h1800, 32'h1200, 32'h900, 32'h200, 32'h1000);
    p0 = npulse;
    pulse_start();
    while (npulse == p0) @(negedge clk);
    n0 = nreq;
    @(posedge clk); #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    clear_model();
    @(negedge clk);
    chk(!busy, "R10 abort in delay idles", busy, 1'b0);
    repeat (30) @(negedge clk);
    chk(nreq == n0, "R10 no request after abort", nreq - n0, 0);
    chk(!done, "R10 abort leaves done low", done, 0);

    // R10: abort while burst outstanding
    cfg(32'h4000, 32'h4800, 32'h4000, 32'h400, 32'h80, 32'h400, 4);
    cur_dly = 4; clear_model();
    build_model(32'h4000, 32'h4800, 32'h4000, 32'h400, 32'h80, 32'h400);
    slow = 1; n0 = nreq; p0 = npulse;
    pulse_start();
    while (!req_valid) @(negedge clk);
    @(posedge clk); #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    slow = 0;
    chk(nreq - n0 == 1, "R10 outstanding burst completes only", nreq - n0, 1);
    chk(npulse == p0, "R10 no pulse after abort", npulse - p0, 0);
    chk(!busy, "R10 idle after burst abort", busy, 0);
    clear_model();

    // R11: restart after abort reloads parameters
    run_job(32'h2000, 32'h2300, 32'h2280, 32'h300, 32'h100, 32'h200, 1, "T4");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule